// File: doc/BRIEF.md
# Receive FIFO with Per-Byte Error Flags

This block buffers received bytes for a serial receiver. Each byte is stored beside its three line-error flags: break, framing error and parity error. The host takes bytes out one at a time. The block shows, as status, the error flags of the byte that will be read next. It also raises a summary flag that stays high while any stored byte carries an error.

The summary flag is driven by a counter of flagged entries. The counter goes up when a flagged byte is accepted and down when a flagged byte is read out. The summary therefore drops in the very cycle after the last flagged byte leaves, no matter how many clean bytes remain behind it.

A write while the FIFO is full is dropped and reported by a one-cycle overrun strobe. A synchronous clear input empties the FIFO in one cycle.

Top module: `rx_errtrack_fifo`

## Requirements
- R1: An accepted write stores the byte and its flags and raises `fillCount` by one on the next cycle. `dataReady` is high whenever `fillCount` is non-zero.
- R2: Bytes leave in the order they were written. `rdData` shows the head byte combinationally, and `rdEn` on a non-empty FIFO removes the head at the clock edge.
- R3: `headStatus` gives the head entry's flags, with bit 2 for break, bit 1 for framing error and bit 0 for parity error. It changes to the flags of the new head right after each read.
- R4: When the FIFO is empty, `headStatus` is 3'b000 and `dataReady` is 0.
- R5: `errAnywhere` is high exactly while at least one stored entry has a non-zero flag field. It falls in the cycle after the last such entry is read or cleared.
- R6: A write and a read in the same cycle, on a FIFO that is neither empty nor full, are both accepted. `fillCount` stays unchanged and the error count nets out.
- R7: A write while `fillCount` equals DEPTH is dropped, even if a read happens in the same cycle. `overrunPulse` is high during that cycle, and the stored contents are not changed.
- R8: `fifoClr` empties the FIFO and clears `errAnywhere` in one cycle. Any write or read in that same cycle is ignored.
- R9: A read of an empty FIFO has no effect, and `rdData` reads as zero while the FIFO is empty.
- R10: DEPTH (a power of two, default 64) entries can be held, and `fillCount` reaches DEPTH when the FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoClr | input | 1 | Synchronous FIFO clear |
| wrEn | input | 1 | Write strobe from the receiver |
| wrData | input | DATA_W | Received byte |
| wrFlags | input | 3 | Flags of the byte: [2] break, [1] framing, [0] parity |
| rdEn | input | 1 | Host read of the head byte |
| rdData | output | DATA_W | Head byte, zero when empty |
| headStatus | output | 3 | Flags of the head entry |
| errAnywhere | output | 1 | Some stored entry is flagged |
| dataReady | output | 1 | FIFO not empty |
| fillCount | output | $clog2(DEPTH)+1 | Number of stored entries |
| overrunPulse | output | 1 | Write dropped because the FIFO was full |

## Verification
The case most likely to break is a flagged byte being written in the same cycle that another flagged byte is read. The error counter must then add one and subtract one in a single update, and the summary flag must not glitch or drift. Random traffic with high flag density and roughly even read and write rates makes this case happen often, including while the FIFO is full, where the write is also dropped. A queue model in the bench predicts the head flags, the summary and the fill level before every edge, and these are compared against the design.

// File: rtl/rx_errtrack_pkg.sv
package rx_errtrack_pkg;
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } errFlags_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifoCtl_t;
endpackage

// File: rtl/rx_errtrack_ctl.sv
module rx_errtrack_ctl
  import rx_errtrack_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fifoClr,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          wrFlagged,
  input  logic          headFlagged,
  output fifoCtl_t      ctl,
  output logic [CW-1:0] fillCount,
  output logic          isEmpty,
  output logic          errAnywhere,
  output logic          overrunPulse
);
  logic [CW-1:0] errCount;
  logic          isFull;

  assign isEmpty = (fillCount == '0);
  assign isFull  = (fillCount == CW'(DEPTH));

  always_comb begin
    ctl.clear    = fifoClr;
    ctl.push     = wrEn && !isFull && !fifoClr;
    ctl.pop      = rdEn && !isEmpty && !fifoClr;
    overrunPulse = wrEn && isFull && !fifoClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount <= '0;
      errCount  <= '0;
    end else if (ctl.clear) begin
      fillCount <= '0;
      errCount  <= '0;
    end else begin
      fillCount <= fillCount + CW'(ctl.push) - CW'(ctl.pop);
      errCount  <= errCount + CW'(ctl.push && wrFlagged)
                            - CW'(ctl.pop && headFlagged);
    end
  end

  assign errAnywhere = (errCount != '0);
endmodule

// File: rtl/rx_errtrack_dp.sv
module rx_errtrack_dp
  import rx_errtrack_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCtl_t          ctl,
  input  logic              isEmpty,
  input  logic [DATA_W-1:0] wrData,
  input  errFlags_t         wrFlags,
  output logic [DATA_W-1:0] rdData,
  output errFlags_t         headFlags,
  output logic              headFlagged
);
  logic [DATA_W-1:0] dataMem [DEPTH];
  errFlags_t         flagMem [DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;

  always_ff @(posedge clk) begin
    if (ctl.push) begin
      dataMem[wrPtr] <= wrData;
      flagMem[wrPtr] <= wrFlags;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (ctl.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctl.push) wrPtr <= wrPtr + 1'b1;
      if (ctl.pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_comb begin
    rdData      = isEmpty ? '0 : dataMem[rdPtr];
    headFlags   = isEmpty ? '0 : flagMem[rdPtr];
    headFlagged = |headFlags;
  end
endmodule

// File: rtl/rx_errtrack_fifo.sv
module rx_errtrack_fifo
  import rx_errtrack_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoClr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        wrFlags,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [2:0]        headStatus,
  output logic              errAnywhere,
  output logic              dataReady,
  output logic [CW-1:0]     fillCount,
  output logic              overrunPulse
);
  fifoCtl_t  ctl;
  errFlags_t headFlags;
  logic      headFlagged;
  logic      isEmpty;

  rx_errtrack_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .fifoClr(fifoClr), .wrEn(wrEn), .rdEn(rdEn),
    .wrFlagged(|wrFlags), .headFlagged(headFlagged), .ctl(ctl),
    .fillCount(fillCount), .isEmpty(isEmpty), .errAnywhere(errAnywhere),
    .overrunPulse(overrunPulse)
  );

  rx_errtrack_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .isEmpty(isEmpty), .wrData(wrData),
    .wrFlags(errFlags_t'(wrFlags)), .rdData(rdData), .headFlags(headFlags),
    .headFlagged(headFlagged)
  );

  assign headStatus = headFlags;
  assign dataReady  = !isEmpty;
endmodule

// File: rtl/rx_errtrack_fifo_chk.sv
module rx_errtrack_fifo_chk #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              fifoClr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic [2:0]        headStatus,
  input logic              errAnywhere,
  input logic              dataReady,
  input logic [CW-1:0]     fillCount,
  input logic              overrunPulse
);
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == '0) |-> (headStatus == 3'b000 && !dataReady && rdData == '0)); // R4
  AST_HEAD_IN_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    (headStatus != 3'b000) |-> errAnywhere); // R5
  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |=> (fillCount == '0 && !errAnywhere)); // R8
  AST_OVERRUN_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    overrunPulse |-> (wrEn && fillCount == CW'(DEPTH))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CW'(DEPTH)); // R10
  AST_NO_GROW_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !fifoClr) |=> fillCount <= $past(fillCount)); // R1
  AST_NO_SHRINK_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn && !fifoClr) |=> fillCount >= $past(fillCount)); // R2
endmodule

bind rx_errtrack_fifo rx_errtrack_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .fifoClr(fifoClr), .wrEn(wrEn), .rdEn(rdEn),
  .rdData(rdData), .headStatus(headStatus), .errAnywhere(errAnywhere),
  .dataReady(dataReady), .fillCount(fillCount), .overrunPulse(overrunPulse)
);

// File: tb/rx_errtrack_fifo_tb.sv
`timescale 1ns/1ps
module rx_errtrack_fifo_tb;
  localparam int DEPTH = 64;
  localparam int DW = 8;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoClr = 0, wrEn = 0, rdEn = 0;
  logic [DW-1:0] wrData = '0;
  logic [2:0] wrFlags = '0;
  logic [DW-1:0] rdData;
  logic [2:0] headStatus;
  logic errAnywhere, dataReady, overrunPulse;
  logic [CW-1:0] fillCount;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [10:0] model[$];

  always #2.5 clk = ~clk;

  rx_errtrack_fifo #(.DEPTH(DEPTH), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .fifoClr(fifoClr), .wrEn(wrEn), .wrData(wrData),
    .wrFlags(wrFlags), .rdEn(rdEn), .rdData(rdData), .headStatus(headStatus),
    .errAnywhere(errAnywhere), .dataReady(dataReady), .fillCount(fillCount),
    .overrunPulse(overrunPulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expFlagged();
    int n = 0;
    foreach (model[i]) if (model[i][10:8] != 3'b000) n++;
    return n;
  endfunction

  function automatic int expHead();
    return (model.size() == 0) ? 0 : int'(model[0]);
  endfunction

  // Drive one cycle, check all outputs before the edge, then advance the model.
  task automatic cycle(input bit w, input logic [7:0] d, input logic [2:0] f,
                       input bit r, input bit c);
    bit wasFull;
    @(negedge clk);
    wrEn = w; wrData = d; wrFlags = f; rdEn = r; fifoClr = c;
    #1;
    chk("R2 rdData", int'(rdData), expHead() & 8'hFF);
    chk("R3/R4 headStatus", int'(headStatus), expHead() >> 8);
    chk("R5 errAnywhere", int'(errAnywhere), int'(expFlagged() != 0));
    chk("R1 fillCount", int'(fillCount), model.size());
    chk("R1/R4 dataReady", int'(dataReady), int'(model.size() != 0));
    wasFull = (model.size() == DEPTH);
    chk("R7 overrunPulse", int'(overrunPulse), int'(w && !c && wasFull));
    if (c) model.delete();
    else begin
      if (r && model.size() != 0) void'(model.pop_front());
      if (w && !wasFull) model.push_back({f, d});
    end
  endtask

  task automatic idle();
    cycle(0, 8'h00, 3'b000, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // Reset state
    #1;
    chk("R4 reset fill", int'(fillCount), 0);
    chk("R5 reset summary", int'(errAnywhere), 0);

    // R9: read of empty does nothing
    cycle(0, 8'h00, 3'b000, 1, 0);
    idle();
    chk("R9 empty read fill", int'(fillCount), 0);

    // R10: fill to DEPTH with flags on entries 5 and 60
    for (int i = 0; i < DEPTH; i++)
      cycle(1, 8'(i + 1), (i == 5) ? 3'b010 : (i == 60 ? 3'b101 : 3'b000), 0, 0);
    idle();
    chk("R10 full level", int'(fillCount), DEPTH);
    // R7: overflow, also with a simultaneous read
    cycle(1, 8'hEE, 3'b111, 0, 0);
    cycle(1, 8'hEF, 3'b111, 1, 0);
    idle();
    chk("R7 dropped write", int'(fillCount), DEPTH - 1);
    // drain: summary falls right after entry 60 leaves (R5)
    while (model.size() != 0) cycle(0, 8'h00, 3'b000, 1, 0);
    idle();
    chk("R5 summary cleared", int'(errAnywhere), 0);

    // R6: simultaneous flagged write and flagged read
    cycle(1, 8'h11, 3'b001, 0, 0);
    cycle(1, 8'h22, 3'b100, 0, 0);
    cycle(1, 8'h33, 3'b010, 1, 0);
    idle();
    chk("R6 level kept", int'(fillCount), 2);
    chk("R6 summary kept", int'(errAnywhere), 1);

    // R8: clear with concurrent write and read
    cycle(1, 8'h44, 3'b111, 1, 1);
    idle();
    chk("R8 cleared level", int'(fillCount), 0);
    chk("R8 cleared summary", int'(errAnywhere), 0);

    // Random phases with varying write/read bias
    for (int ph = 0; ph < 6; ph++) begin
      int wp = (ph % 3 == 0) ? 80 : ((ph % 3 == 1) ? 50 : 25);
      for (int n = 0; n < 1500; n++) begin
        bit w = ($urandom % 100) < wp;
        bit r = ($urandom % 100) < 50;
        bit c = ($urandom % 400) == 0;
        logic [2:0] f = (($urandom % 3) == 0) ? 3'($urandom) : 3'b000;
        cycle(w, 8'($urandom), f, r, c);
      end
    end
    idle();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule